// File: doc/BRIEF.md
# Serial 1-0-1 Pattern Detector (Mealy)

This block watches a single serial bit, sampled on each rising clock edge, and flags every place where the bits 1, 0, 1 arrive in a row. Occurrences may overlap. The final 1 of one match can be the first 1 of the next, so the stream 1,0,1,0,1 gives two hits. The flag is a Mealy output. It is decoded without a register from the current state and the live input bit. It therefore rises in the same cycle that the closing 1 is presented, ahead of the edge that consumes it.

The machine holds its state in a 2-bit register and has no reset pin. It returns to a known state by itself. Any two zero bits in a row leave it idle. The one unused encoding, or any value that no state decode claims, falls back to idle on the next edge. A user who needs a defined start drives two zeros before relying on the flag.

Top module: `mealy101_det`

## Requirements
- R1: State encodings are idle = 2'b00, saw-one = 2'b01, saw-one-zero = 2'b10, and 2'b11 is unused. The state changes only on a rising edge of `clk`.
- R2: `z_out` is 1 exactly when the state is saw-one-zero and `x_in` is 1. It follows `x_in` within the same cycle, with no register between them.
- R3: From idle, `x_in`=1 moves to saw-one and `x_in`=0 stays in idle.
- R4: From saw-one, `x_in`=0 moves to saw-one-zero and `x_in`=1 stays in saw-one.
- R5: From saw-one-zero, `x_in`=1 moves to saw-one, which allows overlapping matches, and `x_in`=0 moves to idle.
- R6: From any register value, two consecutive zero inputs leave the machine idle after at most two edges.
- R7: The unused encoding 2'b11 moves to idle on the next edge for either input value, and `z_out` is 0 while it is held.
- R8: Once two zeros have been applied, `z_out` is 1 in a cycle exactly when that cycle's input and the two before it were 1, 0, 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| x_in | input | 1 | Serial data bit |
| z_out | output | 1 | Match flag, decoded combinationally |

## Verification
The block has no parameters, so the bench builds it as it is. That leaves room to run all 256 eight-bit input streams back to back, checked against an arithmetic three-bit history model. The bench also places each of the four register encodings, including the unused one, in front of both input values. It then probes the following state through the flag alone, and it replays the two-zero recovery from every encoding.

// File: rtl/mealy101_pkg.sv
package mealy101_pkg;
  localparam int unsigned STATE_W = 2;

  typedef logic [STATE_W-1:0] seq_state_t;

  localparam seq_state_t ST_IDLE   = 2'b00;
  localparam seq_state_t ST_SAW1   = 2'b01;
  localparam seq_state_t ST_SAW10  = 2'b10;
  localparam seq_state_t ST_UNUSED = 2'b11;
endpackage

// File: rtl/mealy101_next.sv
module mealy101_next
  import mealy101_pkg::*;
(
  input  seq_state_t cur_st,
  input  logic       bit_in,
  output seq_state_t nxt_st
);
  always_comb begin
    nxt_st = ST_IDLE;
    case (cur_st)
      ST_IDLE:  nxt_st = bit_in ? ST_SAW1 : ST_IDLE;
      ST_SAW1:  nxt_st = bit_in ? ST_SAW1 : ST_SAW10;
      ST_SAW10: nxt_st = bit_in ? ST_SAW1 : ST_IDLE;
      default:  nxt_st = ST_IDLE;
    endcase
  end
endmodule

// File: rtl/mealy101_sreg.sv
module mealy101_sreg
  import mealy101_pkg::*;
(
  input  logic       clk,
  input  seq_state_t state_d,
  output seq_state_t state_q
);
  always_ff @(posedge clk) begin
    state_q <= state_d;
  end
endmodule

// File: rtl/mealy101_out.sv
module mealy101_out
  import mealy101_pkg::*;
(
  input  seq_state_t cur_st,
  input  logic       bit_in,
  output logic       hit
);
  always_comb begin
    hit = 1'b0;
    if (cur_st == ST_SAW10) begin
      hit = bit_in;
    end
  end
endmodule

// File: rtl/mealy101_det.sv
module mealy101_det
  import mealy101_pkg::*;
(
  input  logic clk,
  input  logic x_in,
  output logic z_out
);
  seq_state_t state_q;
  seq_state_t state_d;

  mealy101_next u_next (
    .cur_st (state_q),
    .bit_in (x_in),
    .nxt_st (state_d)
  );

  mealy101_sreg u_sreg (
    .clk     (clk),
    .state_d (state_d),
    .state_q (state_q)
  );

  mealy101_out u_out (
    .cur_st (state_q),
    .bit_in (x_in),
    .hit    (z_out)
  );
endmodule

// File: rtl/mealy101_det_chk.sv
module mealy101_det_chk
  import mealy101_pkg::*;
(
  input logic       clk,
  input logic       x_in,
  input logic       z_out,
  input seq_state_t st
);
  logic armed = 1'b0;
  always_ff @(posedge clk) armed <= 1'b1;

  // R2: a hit needs a live 1 on the input
  assert_hit_needs_one_R2: assert property (@(posedge clk) disable iff (!armed)
    z_out |-> x_in);

  // R5: a hit leaves the machine in saw-one (overlap)
  assert_hit_overlap_R5: assert property (@(posedge clk) disable iff (!armed)
    z_out |=> (st == ST_SAW1));

  // R3
  assert_idle_one_R3: assert property (@(posedge clk) disable iff (!armed)
    (st == ST_IDLE && x_in) |=> (st == ST_SAW1));

  // R4
  assert_saw1_zero_R4: assert property (@(posedge clk) disable iff (!armed)
    (st == ST_SAW1 && !x_in) |=> (st == ST_SAW10));

  // R7
  assert_unused_recover_R7: assert property (@(posedge clk) disable iff (!armed)
    (st == ST_UNUSED) |=> (st == ST_IDLE));
endmodule

bind mealy101_det mealy101_det_chk u_chk (
  .clk   (clk),
  .x_in  (x_in),
  .z_out (z_out),
  .st    (state_q)
);

// File: tb/mealy101_det_bench.sv
module mealy101_det_bench;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic x_in = 1'b0;
  logic z_out;
  int   n_chk = 0;
  int   n_bad = 0;
  bit   done = 1'b0;
  logic h1 = 1'b0;
  logic h2 = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mealy101_det u_mealy101_det (
    .clk   (clk),
    .x_in  (x_in),
    .z_out (z_out)
  );

  task automatic chk(input logic xv, input logic expz, input string tag);
    @(negedge clk);
    x_in = xv;
    #1;
    n_chk++;
    if (z_out !== expz) begin
      n_bad++;
      $display("FAIL %s: z_out=%0b expected %0b", tag, z_out, expz);
    end
  endtask

  task automatic sync_zeros();
    chk(1'b0, 1'b0, "R2 zero input");
    chk(1'b0, 1'b0, "R2 zero input");
  endtask

  // place register value s while presenting xv, check z_out in that cycle
  task automatic put_state(input logic [1:0] s, input logic xv, input string tag);
    logic expz;
    @(negedge clk);
    force u_mealy101_det.u_sreg.state_q = s;
    x_in = xv;
    #1;
    release u_mealy101_det.u_sreg.state_q;
    expz = (s == 2'b10) && xv;
    n_chk++;
    if (z_out !== expz) begin
      n_bad++;
      $display("FAIL %s: z_out=%0b expected %0b", tag, z_out, expz);
    end
  endtask

  function automatic logic [1:0] model_next(input logic [1:0] s, input logic xv);
    case (s)
      2'b00: return xv ? 2'b01 : 2'b00;
      2'b01: return xv ? 2'b01 : 2'b10;
      2'b10: return xv ? 2'b01 : 2'b00;
      default: return 2'b00;
    endcase
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: done=0 expected 1");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    // R6: from an unknown power-up value, two zeros give idle
    sync_zeros();
    chk(1'b1, 1'b0, "R6 first one after sync");
    chk(1'b0, 1'b0, "R4 one-zero");
    chk(1'b1, 1'b1, "R2 hit in same cycle");
    chk(1'b0, 1'b0, "R5 overlap zero");
    chk(1'b1, 1'b1, "R5 overlapping hit");
    chk(1'b1, 1'b0, "R4 repeated one");

    // R8: every 8-bit stream back to back, checked against input history
    sync_zeros();
    h1 = 1'b0; h2 = 1'b0;
    for (int p = 0; p < 256; p++) begin
      for (int b = 7; b >= 0; b--) begin
        logic xv;
        xv = p[b];
        chk(xv, xv & ~h1 & h2, "R8 stream sweep");
        h2 = h1;
        h1 = xv;
      end
    end

    // R1 R3 R4 R5 R7: every encoding with each input, then probe next state
    for (int s = 0; s < 4; s++) begin
      for (int xi = 0; xi < 2; xi++) begin
        for (int pr = 0; pr < 2; pr++) begin
          logic [1:0] ns;
          string tg;
          ns = model_next(s[1:0], xi[0]);
          tg = (s == 0) ? "R3 idle step" : (s == 1) ? "R4 saw1 step" :
               (s == 2) ? "R5 saw10 step" : "R7 unused step";
          sync_zeros();
          put_state(s[1:0], xi[0], tg);
          if (pr == 0) begin
            chk(1'b1, ns == 2'b10, tg);
          end else begin
            chk(1'b0, 1'b0, tg);
            chk(1'b1, ns == 2'b01, tg);
          end
        end
      end
    end

    // R6: two zeros from each encoding reach idle
    for (int s = 0; s < 4; s++) begin
      sync_zeros();
      put_state(s[1:0], 1'b0, "R6 forced start");
      chk(1'b0, 1'b0, "R6 second zero");
      chk(1'b1, 1'b0, "R6 idle then one");
      chk(1'b0, 1'b0, "R6 one-zero");
      chk(1'b1, 1'b1, "R6 hit after recovery");
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule